// File: doc/BRIEF.md
# Flag-Based Interrupt Controller

The block gathers single-cycle event strobes from three sources (a watchdog timeout, an alarm match and a power-fail detect). Each strobe latches a sticky flag. A small register bus gives read and write access to a control register and read-only access to the flags. A read of the flags returns them and clears them all. The flags feed one interrupt pin. Each source has its own enable, and two control bits set the pin's behaviour. One selects the polarity and drive style: active-high push-pull, or active-low open-drain. The other selects the timing: a level held until the host reads, or a pulse of fixed width counted in timebase ticks. The fixed-width pulse is meant to reset a host.

The pin leaves the block as an output-enable and a data value, so a pad cell can build either drive style. In push-pull mode nothing is driven while the main supply is reported absent. Open-drain mode keeps working on backup power.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the flags read 0x00 and the control register reads 0x00. The control value 0x00 means all sources disabled, active-low open-drain, level mode. The pin output-enable is 0.
- R2: A strobe on `evt_wdog`, `evt_alarm` or `evt_pfail` sets flag bit 0, 1 or 2 respectively at the next clock edge. This happens whatever the enable bits hold. A flag stays set until the flags register is read.
- R3: A read of the flags (address 1) returns the flags held before the read. After that edge every flag is 0, except that a strobe in the same cycle as the read leaves its own flag set.
- R4: An interrupt starts only from a strobe whose enable bit is 1. Control bits 0, 1 and 2 enable the watchdog, alarm and power-fail sources. A strobe on a disabled source sets its flag and leaves the pin untouched.
- R5: Control bits 2:0 hold the enables, bit 3 selects active-high, and bit 4 selects pulse mode. A write to address 0 loads bits 4:0, and bits 7:5 read back as 0. A write to address 1 has no effect.
- R6: In level mode the interrupt stays active through any number of ticks. It ends at the edge after a read of the flags or of the control register.
- R7: In pulse mode the interrupt stays active for exactly PULSE_TICKS tick cycles after the trigger and then ends. A read of the control register does not end it.
- R8: In pulse mode a read of the flags ends the interrupt at the next edge, before the full width has elapsed.
- R9: In active-high mode, `irq_oe` equals `supply_ok`, and `irq_out` is 1 only when the interrupt is active and `supply_ok` is 1.
- R10: In active-low mode, `irq_oe` is 1 exactly while the interrupt is active and `irq_out` is always 0. This holds whatever `supply_ok` is.
- R11: An enabled strobe while the interrupt is already active restarts it, and in pulse mode the full width is counted again. The restart also happens when the strobe arrives in the same cycle as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus access strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = control register, 1 = flags register |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data for `req_addr`, combinational |
| evt_wdog | input | 1 | Watchdog timeout strobe |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_pfail | input | 1 | Power-fail detect strobe |
| supply_ok | input | 1 | Main supply above the switch threshold |
| tick | input | 1 | Timebase strobe for the pulse width |
| irq_oe | output | 1 | Interrupt pin output-enable |
| irq_out | output | 1 | Interrupt pin data value |

## Verification
The hardest corner to reach is a collision at one clock edge: a host read of the flags and a fresh enabled strobe. That read would both clear the flags and cut short a pulse in progress. The bench therefore places the strobe and the read in the same cycle, part-way through a counted pulse. It then checks that the flag survives the read and that the pulse restarts at full width, counted tick by tick. It also drops `supply_ok` while an active-high interrupt is held, then restores it, to show that the output returns without a new event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC     = 3;
    localparam int DATA_W   = 8;
    localparam int CTRL_W   = 5;

    localparam int SRC_WDOG  = 0;
    localparam int SRC_ALARM = 1;
    localparam int SRC_PFAIL = 2;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_FLAGS = 1'b1;

    // packed MSB first: bit4 pulse, bit3 act_high, bits2:0 enables
    typedef struct packed {
        logic            pulse;
        logic            act_high;
        logic [NSRC-1:0] en;
    } ctrl_t;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NSRC-1:0]   flags_i,
    output ctrl_t             ctrl_o,
    output logic              rd_flags_o,
    output logic              rd_ctrl_o,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        ctrl_t ctrl;
    } regs_s;

    regs_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_valid && req_write && (req_addr == ADDR_CTRL))
            st_d.ctrl = ctrl_t'(req_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o     = st_q.ctrl;
    assign rd_flags_o = req_valid && !req_write && (req_addr == ADDR_FLAGS);
    assign rd_ctrl_o  = req_valid && !req_write && (req_addr == ADDR_CTRL);

    always_comb begin
        rsp_rdata = '0;
        if (req_addr == ADDR_CTRL) rsp_rdata[CTRL_W-1:0] = st_q.ctrl;
        else                       rsp_rdata[NSRC-1:0]   = flags_i;
    end

    AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_FLAGS) |=> $stable(st_q.ctrl)); // R5

endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            rd_clr_i,
    output logic [NSRC-1:0] flags_o,
    output logic            trig_o
);

    typedef struct packed {
        logic [NSRC-1:0] flags;
    } flg_s;

    flg_s st_d, st_q;
    logic [NSRC-1:0] nxt;

    // per source: a strobe outranks the clearing read
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign nxt[g] = evt_i[g] | (st_q.flags[g] & ~rd_clr_i);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign trig_o  = |(evt_i & en_i);

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> (|st_q.flags)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(|evt_i)) |=> (st_q.flags == '0)); // R3

endmodule

// File: rtl/irqc_pulse.sv
module irqc_pulse #(
    parameter int PULSE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic rd_flags_i,
    input  logic rd_ctrl_i,
    input  logic pulse_mode_i,
    input  logic tick_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_TICKS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } pls_s;

    pls_s st_d, st_q;
    logic clr;

    assign clr = rd_flags_i | (rd_ctrl_i & ~pulse_mode_i);

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.act = 1'b1;
            st_d.cnt = CNT_FULL;
        end else if (st_q.act) begin
            if (clr) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else if (pulse_mode_i && tick_i) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
                if (st_q.cnt == CNT_ONE) st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.act;

    AST_TRIG_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> st_q.act); // R4

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !pulse_mode_i && !trig_i && !rd_flags_i && !rd_ctrl_i) |=> st_q.act); // R6

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && pulse_mode_i && !trig_i && !rd_flags_i && tick_i && st_q.cnt == CNT_ONE)
        |=> !st_q.act); // R7

    AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags_i && !trig_i) |=> !st_q.act); // R8

endmodule

// File: rtl/irqc_pin.sv
module irqc_pin (
    input  logic active_i,
    input  logic act_high_i,
    input  logic supply_ok_i,
    output logic pin_oe_o,
    output logic pin_out_o
);

    always_comb begin
        if (act_high_i) begin
            pin_oe_o  = supply_ok_i;
            pin_out_o = active_i & supply_ok_i;
        end else begin
            pin_oe_o  = active_i;
            pin_out_o = 1'b0;
        end
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int PULSE_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              evt_wdog,
    input  logic              evt_alarm,
    input  logic              evt_pfail,
    input  logic              supply_ok,
    input  logic              tick,
    output logic              irq_oe,
    output logic              irq_out
);

    ctrl_t           ctrl;
    logic            rd_flags, rd_ctrl, trig, active;
    logic [NSRC-1:0] flags, evt;

    always_comb begin
        evt            = '0;
        evt[SRC_WDOG]  = evt_wdog;
        evt[SRC_ALARM] = evt_alarm;
        evt[SRC_PFAIL] = evt_pfail;
    end

    irqc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .flags_i   (flags),
        .ctrl_o    (ctrl),
        .rd_flags_o(rd_flags),
        .rd_ctrl_o (rd_ctrl),
        .rsp_rdata (rsp_rdata)
    );

    irqc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .en_i    (ctrl.en),
        .rd_clr_i(rd_flags),
        .flags_o (flags),
        .trig_o  (trig)
    );

    irqc_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .rd_flags_i  (rd_flags),
        .rd_ctrl_i   (rd_ctrl),
        .pulse_mode_i(ctrl.pulse),
        .tick_i      (tick),
        .active_o    (active)
    );

    irqc_pin u_pin (
        .active_i   (active),
        .act_high_i (ctrl.act_high),
        .supply_ok_i(supply_ok),
        .pin_oe_o   (irq_oe),
        .pin_out_o  (irq_out)
    );

    AST_HIGH_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.act_high && !supply_ok) |-> (!irq_oe && !irq_out)); // R9

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.act_high |-> !irq_out); // R10

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.act_high && !active && (evt & ctrl.en) == '0 && !rd_flags && !rd_ctrl)
        |=> !irq_oe || ctrl.act_high); // R4

endmodule

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;

    localparam int TICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rsp_rdata;
    logic       evt_wdog = 0, evt_alarm = 0, evt_pfail = 0;
    logic       supply_ok = 1'b1, tick = 1'b0;
    logic       irq_oe, irq_out;

    always #2 clk = ~clk;

    irq_flag_ctrl #(.PULSE_TICKS(TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .evt_wdog(evt_wdog), .evt_alarm(evt_alarm), .evt_pfail(evt_pfail),
        .supply_ok(supply_ok), .tick(tick), .irq_oe(irq_oe), .irq_out(irq_out)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string cur = "R1";

    // behavioural reference state
    bit [2:0] m_flags;
    bit [4:0] m_ctrl;
    bit       m_act;
    int       m_cnt;

    task automatic chk(string rq, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit rdf, rdc, trig, pulse;
        bit [2:0] ev;
        ev    = {evt_pfail, evt_alarm, evt_wdog};
        rdf   = req_valid && !req_write && req_addr;
        rdc   = req_valid && !req_write && !req_addr;
        trig  = (ev & m_ctrl[2:0]) != 0;
        pulse = m_ctrl[4];
        if (trig) begin
            m_act = 1; m_cnt = TICKS;
        end else if (m_act) begin
            if (rdf || (rdc && !pulse)) begin
                m_act = 0; m_cnt = 0;
            end else if (pulse && tick) begin
                if (m_cnt == 1) m_act = 0;
                m_cnt = m_cnt - 1;
            end
        end
        m_flags = ev | (rdf ? 3'b000 : m_flags);
        if (req_valid && req_write && !req_addr) m_ctrl = req_wdata[4:0];
    endtask

    task automatic compare();
        bit eoe, eout;
        bit [7:0] erd;
        if (m_ctrl[3]) begin eoe = supply_ok; eout = m_act && supply_ok; end
        else           begin eoe = m_act;     eout = 1'b0;               end
        erd = req_addr ? {5'b0, m_flags} : {3'b0, m_ctrl};
        chk(cur, "irq_oe", {7'b0, irq_oe}, {7'b0, eoe});
        chk(cur, "irq_out", {7'b0, irq_out}, {7'b0, eout});
        chk(cur, "rsp_rdata", rsp_rdata, erd);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        req_valid = 0; req_write = 0; evt_wdog = 0; evt_alarm = 0; evt_pfail = 0; tick = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic a, logic [7:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; step();
    endtask

    task automatic rd(logic a);
        req_valid = 1; req_write = 0; req_addr = a; step();
    endtask

    task automatic fire(bit [2:0] m);
        {evt_pfail, evt_alarm, evt_wdog} = m; step();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick = 1; step(); end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, run hung");
        summary();
        $finish;
    end

    initial begin
        m_flags = 0; m_ctrl = 0; m_act = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur = "R1";
        req_addr = 0; #0;
        chk("R1", "ctrl reset", rsp_rdata, 8'h00);
        chk("R1", "oe reset", {7'b0, irq_oe}, 8'h00);
        req_addr = 1; #1;
        chk("R1", "flags reset", rsp_rdata, 8'h00);
        idle(2);

        cur = "R5";
        wr(0, 8'hFF);
        req_addr = 0; #1;
        chk("R5", "ctrl readback", rsp_rdata, 8'h1F);
        wr(1, 8'h07);                       // write to flags: no effect
        req_addr = 1; #1;
        chk("R5", "flags after write", rsp_rdata, 8'h00);
        wr(0, 8'h00);

        cur = "R2";                         // all sources disabled
        fire(3'b001); fire(3'b010); fire(3'b100);
        chk("R4", "pin idle with enables off", {7'b0, irq_oe}, 8'h00);
        idle(2);
        req_addr = 1; #1;
        chk("R2", "flags sticky", rsp_rdata, 8'h07);

        cur = "R3";
        rd(1);
        chk("R3", "flags cleared", rsp_rdata, 8'h00);
        req_valid = 1; req_write = 0; req_addr = 1; evt_alarm = 1; step();
        chk("R3", "event beats read", rsp_rdata, 8'h02);
        rd(1);

        cur = "R6";                         // level, active-low, wdog enabled
        wr(0, 8'h01);
        fire(3'b010);                       // disabled source
        chk("R4", "alarm disabled no pin", {7'b0, irq_oe}, 8'h00);
        fire(3'b001);
        chk("R4", "enabled source drives", {7'b0, irq_oe}, 8'h01);
        ticks(TICKS + 2);
        chk("R6", "level held through ticks", {7'b0, irq_oe}, 8'h01);
        rd(0);
        chk("R6", "ctrl read ends level", {7'b0, irq_oe}, 8'h00);
        fire(3'b001); idle(3);
        rd(1);
        chk("R6", "flags read ends level", {7'b0, irq_oe}, 8'h00);

        cur = "R10";
        wr(0, 8'h04);
        supply_ok = 0;
        fire(3'b100);
        chk("R10", "open drain on backup", {7'b0, irq_oe}, 8'h01);
        chk("R10", "open drain data low", {7'b0, irq_out}, 8'h00);
        supply_ok = 1;
        rd(1);

        cur = "R9";                         // active-high, level, all enabled
        wr(0, 8'h0F);
        chk("R9", "push-pull idle drives low", {7'b0, irq_oe}, 8'h01);
        fire(3'b100);
        chk("R9", "high asserted", {7'b0, irq_out}, 8'h01);
        supply_ok = 0; step();
        chk("R9", "no drive without supply", {7'b0, irq_oe}, 8'h00);
        chk("R9", "no high without supply", {7'b0, irq_out}, 8'h00);
        supply_ok = 1; step();
        chk("R9", "high returns with supply", {7'b0, irq_out}, 8'h01);
        rd(1);

        cur = "R7";                         // pulse, active-low, all enabled
        wr(0, 8'h17);
        fire(3'b001);
        ticks(TICKS - 1);
        idle(2);
        rd(0);                              // ctrl read must not end a pulse
        chk("R7", "pulse survives ctrl read", {7'b0, irq_oe}, 8'h01);
        ticks(1);
        chk("R7", "pulse ends after width", {7'b0, irq_oe}, 8'h00);
        rd(1);

        cur = "R8";
        fire(3'b010);
        ticks(2);
        rd(1);
        chk("R8", "flags read cuts pulse", {7'b0, irq_oe}, 8'h00);

        cur = "R11";
        fire(3'b100);
        ticks(2);
        req_valid = 1; req_write = 0; req_addr = 1; evt_wdog = 1; step();
        chk("R11", "retrigger beats read", {7'b0, irq_oe}, 8'h01);
        ticks(TICKS - 1);
        chk("R11", "full width recounted", {7'b0, irq_oe}, 8'h01);
        ticks(1);
        chk("R11", "recounted pulse ends", {7'b0, irq_oe}, 8'h00);
        rd(1);
        idle(2);

        summary();
        $finish;
    end

endmodule